// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. A 3-bit selector taken from the low bits of the instruction picks one of six tests, which is applied to a 32-bit word placed on the processor bus. When the load strobe is high at a clock edge, the result is written into a private one-bit condition flag. Software cannot read or write this flag.

The flag feeds the branch step that follows. In that step the sequencer raises a program-counter load request. The block passes the request on only while the flag is set. The branch target may be driven onto the bus whether or not the branch is taken, because only the load of the program counter is gated.

The all-zero test is a wide NOR over the bus word, built as per-lane NOR terms whose results are ANDed together. The sign tests use only the most significant bit.

Top module: `brc_eval`

## Requirements
- R1: While `rstN` is low the flag is 0, and `pcLoadOk` is 0 even when `pcLoadReq` is 1.
- R2: Selector value 0 (never) loads 0 into the flag.
- R3: Selector value 1 (always) loads 1 into the flag.
- R4: Selector value 2 loads 1 when all 32 bus bits are 0, and loads 0 when any bit is set, including a single bit.
- R5: Selector value 3 loads 1 when any bus bit is set, and loads 0 when the word is all zero.
- R6: Selector value 4 loads 1 when bus bit 31 is 0 (positive or zero), otherwise 0.
- R7: Selector value 5 loads 1 when bus bit 31 is 1 (negative), otherwise 0.
- R8: Selector values 6 and 7 load 0 into the flag for any bus word.
- R9: The flag changes only at a rising clock edge where `conLoad` is 1. With `conLoad` at 0, changes on the bus or the selector leave it unchanged.
- R10: `pcLoadOk` equals `pcLoadReq` AND the flag in the same cycle. `pcLoadReq` has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busWord | input | 32 | Word under test, taken from the bus |
| condCode | input | 3 | Selector for the condition test |
| conLoad | input | 1 | Writes the test result into the flag at the next edge |
| pcLoadReq | input | 1 | Program-counter load request from the sequencer |
| condFlag | output | 1 | Stored condition flag |
| pcLoadOk | output | 1 | Program-counter load request, qualified by the flag |

## Verification
A result that is loaded appears on `condFlag` one clock edge after the cycle in which `conLoad` is high. `pcLoadOk` follows `pcLoadReq` in the same cycle, without any register in between.

The driver changes inputs on the falling edge and queues the expected flag and qualified load for that cycle. The monitor removes each queued item 1 ns after the next rising edge. That is the first point at which the new flag is valid, and the inputs of the cycle are still applied. Cycles with `conLoad` low also queue an item, which carries the unchanged flag, so the hold behaviour of R9 is compared at the same point in each cycle.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    COND_NEVER   = 3'd0,
    COND_ALWAYS  = 3'd1,
    COND_ZERO    = 3'd2,
    COND_NONZERO = 3'd3,
    COND_POS     = 3'd4,
    COND_NEG     = 3'd5,
    COND_RSV6    = 3'd6,
    COND_RSV7    = 3'd7
  } condSel_e;

  typedef struct packed {
    logic latchCond;
    logic gatePc;
  } strobe_t;

endpackage

// File: rtl/brc_datapath.sv
module brc_datapath
  import brc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LANE  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] busWord,
  input  logic [2:0]       condCode,
  input  strobe_t          strobes,
  output logic             conFlag
);

  localparam int LANES = WIDTH / LANE;

  logic [LANES-1:0] laneZero;
  logic             wordZero;
  logic             signBit;
  logic             condNext;

  // Zero detect: one NOR per lane, then AND across the lanes.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneZero[g] = ~|busWord[g*LANE +: LANE];
  end

  assign wordZero = &laneZero;
  assign signBit  = busWord[WIDTH-1];

  always_comb begin
    unique case (condSel_e'(condCode))
      COND_NEVER:   condNext = 1'b0;
      COND_ALWAYS:  condNext = 1'b1;
      COND_ZERO:    condNext = wordZero;
      COND_NONZERO: condNext = ~wordZero;
      COND_POS:     condNext = ~signBit;
      COND_NEG:     condNext = signBit;
      COND_RSV6:    condNext = 1'b0;
      COND_RSV7:    condNext = 1'b0;
      default:      condNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  conFlag <= 1'b0;
    else if (strobes.latchCond) conFlag <= condNext;
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchCond |=> $stable(conFlag));

  // R2
  never_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchCond && condCode == 3'd0) |=> !conFlag);

  // R3
  always_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchCond && condCode == 3'd1) |=> conFlag);

  // R4
  zero_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchCond && condCode == 3'd2 && busWord == '0) |=> conFlag);

  // R8
  reserved_codes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchCond && condCode[2:1] == 2'b11) |=> !conFlag);

endmodule

// File: rtl/brc_control.sv
module brc_control
  import brc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    conLoad,
  input  logic    pcLoadReq,
  input  logic    condFlag,
  output strobe_t strobes,
  output logic    pcLoadOk
);

  assign strobes.latchCond = conLoad;
  assign strobes.gatePc    = pcLoadReq;
  assign pcLoadOk          = strobes.gatePc & condFlag;

  // R10
  no_load_when_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !condFlag |-> !pcLoadOk);

  // R10
  load_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoadOk |-> pcLoadReq);

endmodule

// File: rtl/brc_eval.sv
module brc_eval
  import brc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] busWord,
  input  logic [2:0]  condCode,
  input  logic        conLoad,
  input  logic        pcLoadReq,
  output logic        condFlag,
  output logic        pcLoadOk
);

  strobe_t strobes;

  brc_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .conLoad   (conLoad),
    .pcLoadReq (pcLoadReq),
    .condFlag  (condFlag),
    .strobes   (strobes),
    .pcLoadOk  (pcLoadOk)
  );

  brc_datapath #(.WIDTH(32), .LANE(8)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busWord  (busWord),
    .condCode (condCode),
    .strobes  (strobes),
    .conFlag  (condFlag)
  );

endmodule

// File: tb/brc_eval_test.sv
`timescale 1ns/1ps
module brc_eval_test;

  typedef struct {
    logic  expFlag;
    logic  expOk;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busWord = '0;
  logic [2:0]  condCode = '0;
  logic        conLoad = 1'b0;
  logic        pcLoadReq = 1'b0;
  logic        condFlag;
  logic        pcLoadOk;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  logic  model = 1'b0;

  always #2 clk = ~clk;

  brc_eval uut (
    .clk(clk), .rstN(rstN), .busWord(busWord), .condCode(condCode),
    .conLoad(conLoad), .pcLoadReq(pcLoadReq),
    .condFlag(condFlag), .pcLoadOk(pcLoadOk)
  );

  function automatic logic refCond(input logic [31:0] b, input logic [2:0] c);
    case (c)
      3'd1:    return 1'b1;
      3'd2:    return (b == 32'd0);
      3'd3:    return (b != 32'd0);
      3'd4:    return !b[31];
      3'd5:    return b[31];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] b, input logic [2:0] c,
                       input logic ld, input logic req, input string tag);
    item_t it;
    @(negedge clk);
    busWord = b; condCode = c; conLoad = ld; pcLoadReq = req;
    if (ld) model = refCond(b, c);
    it.expFlag = model;
    it.expOk   = model & req;
    it.tag     = tag;
    sb.push_back(it);
  endtask

  // Monitor: each queued item is due just after the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(condFlag, it.expFlag, {it.tag, " flag"});
        check(pcLoadOk, it.expOk,   {it.tag, " pcLoadOk"});
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset holds the flag low and masks a pending request
    pcLoadReq = 1'b1; condCode = 3'd1; conLoad = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(condFlag, 1'b0, "R1 flag in reset");
    check(pcLoadOk, 1'b0, "R1 pcLoadOk in reset");
    @(negedge clk);
    conLoad = 1'b0; pcLoadReq = 1'b0; rstN = 1'b1;

    drive(32'hFFFF_FFFF, 3'd1, 1'b1, 1'b1, "R3 always");
    drive(32'hFFFF_FFFF, 3'd0, 1'b1, 1'b1, "R2 never");
    drive(32'h0000_0000, 3'd2, 1'b1, 1'b1, "R4 zero word");
    drive(32'h0000_0001, 3'd2, 1'b1, 1'b1, "R4 bit0 set");
    drive(32'h8000_0000, 3'd2, 1'b1, 1'b0, "R4 bit31 set");
    drive(32'h0001_0000, 3'd3, 1'b1, 1'b1, "R5 nonzero");
    drive(32'h0000_0000, 3'd3, 1'b1, 1'b1, "R5 zero word");
    drive(32'h7FFF_FFFF, 3'd4, 1'b1, 1'b1, "R6 positive");
    drive(32'h0000_0000, 3'd4, 1'b1, 1'b1, "R6 zero counts positive");
    drive(32'h8000_0000, 3'd4, 1'b1, 1'b1, "R6 negative");
    drive(32'h8000_0000, 3'd5, 1'b1, 1'b1, "R7 negative");
    drive(32'h7FFF_FFFF, 3'd5, 1'b1, 1'b1, "R7 positive");
    drive(32'h0000_0000, 3'd1, 1'b1, 1'b0, "R3 set before reserved");
    drive(32'h0000_0000, 3'd6, 1'b1, 1'b1, "R8 code6");
    drive(32'h0000_0000, 3'd1, 1'b1, 1'b1, "R3 set again");
    drive(32'h8000_0000, 3'd7, 1'b1, 1'b1, "R8 code7");
    // R9: flag held while load strobe is low, inputs churning
    drive(32'h0000_0000, 3'd1, 1'b1, 1'b1, "R9 preset");
    drive(32'hFFFF_FFFF, 3'd0, 1'b0, 1'b1, "R9 hold set");
    drive(32'h1234_5678, 3'd6, 1'b0, 1'b0, "R9 hold set 2");
    drive(32'h1234_5678, 3'd2, 1'b1, 1'b0, "R9 clear via load");
    drive(32'h0000_0000, 3'd1, 1'b0, 1'b1, "R9 hold clear");
    // R10: request toggling does not disturb the flag
    drive(32'h0000_0000, 3'd1, 1'b1, 1'b0, "R10 set");
    drive(32'h0000_0000, 3'd1, 1'b0, 1'b1, "R10 req high");
    drive(32'h0000_0000, 3'd1, 1'b0, 1'b0, "R10 req low");
    drive(32'h0000_0000, 3'd1, 1'b0, 1'b1, "R10 req high again");

    @(negedge clk);
    conLoad = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule